// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface and owns the command pins from reset until the memory can take normal traffic. While reset is held, and for a programmable settling interval after it, the block keeps clock-enable high and every byte mask high. During that time it drives a no-operation command with chip select asserted.

After the settling interval it closes all banks with one precharge-all command. It then waits the row-precharge time and issues a train of auto-refresh commands, one refresh-cycle time apart. Next it loads the mode register from the configuration inputs and waits the mode-register recovery time. Only then does it raise `init_done`, which stays high until the next reset.

All waits are whole clock cycles set by parameters. Spacing parameters are measured from one command cycle to the next. A read/write engine can take over the pins once `init_done` is high. Periodic refresh is outside this block.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and for exactly STABLE_CYC cycles after it falls, the pins show a no-operation command: cs_n=0, ras_n=1, cas_n=1, we_n=1. In the same window sd_cke=1, every sd_dqm bit is 1, sd_addr and sd_ba are zero, and init_done=0.
- R2: The first command after the settling interval is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0. In that cycle sd_addr bit 10 is 1, every other address bit is 0, and sd_ba is zero.
- R3: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, address and bank zero) appears exactly T_RP_CYC cycles after the precharge-all cycle.
- R4: Auto-refreshes follow one another every T_RC_CYC cycles. Their number is REFRESH_COUNT, but never fewer than 8.
- R5: The mode-register load (cs_n=ras_n=cas_n=we_n=0) comes T_RC_CYC cycles after the last refresh. Its address carries: burst-length code in bits 2..0, burst-order select in bit 3, CAS latency in bits 6..4, and the single-write select in bit 9. Bits 8..7 and 11..10 are zero, and sd_ba is zero.
- R6: init_done rises exactly T_RSC_CYC cycles after the mode-register load cycle. It then stays high with the pins at no-operation until reset.
- R7: Every cycle that is not one of the commands above shows no-operation with zero address and bank. Changes on the mode inputs reach the pins only in the mode-register load cycle.
- R8: A spacing parameter (T_RP_CYC, T_RC_CYC, T_RSC_CYC) below 2 behaves as 2.
- R9: Reset asserted at any point, including a cycle where a command is on the pins, returns the block to the R1 state. After release the whole sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_burst_len | input | 3 | Burst-length code placed in the mode word |
| mode_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| mode_cas_lat | input | 3 | CAS latency code placed in the mode word |
| mode_single_write | input | 1 | 1 selects single-location writes |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dqm | output | DQM_W | Byte data masks, held high |
| init_done | output | 1 | Memory ready for normal use |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both.

The first pair is the mode-register load and a change on the mode inputs. The bench changes the mode inputs from a shift register on every cycle, so they change in the very cycle the load is on the pins. The reference model builds the expected mode word from the inputs present in that cycle and expects zero address in every other cycle.

The second pair is reset and a command issue. The bench raises reset right after a refresh command has been seen on the pins. It then checks that the next cycle already shows no-operation with `init_done` low, and that the full sequence repeats on the same cycle grid after release.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command pin encoding, ordered {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_ARF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_IDLE = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_PALL,
        ST_GAP_RP,
        ST_ARF,
        ST_GAP_RC,
        ST_LMR,
        ST_GAP_RSC,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic [2:0] burst_len;
        logic       interleave;
        logic [2:0] cas_lat;
        logic       single_write;
    } mode_cfg_t;

    localparam int unsigned PALL_BIT = 10;

    function automatic int unsigned at_least(input int unsigned v, input int unsigned floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Standard mode word layout, 12 address bits
    function automatic logic [11:0] mode_word(input mode_cfg_t m);
        return {2'b00, m.single_write, 2'b00, m.cas_lat, m.interleave, m.burst_len};
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R3/R4/R6 spacing depends on a strict one-per-cycle countdown
    a_r3_timer_steps: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r6_timer_parks: assert property (@(posedge clk) disable iff (rst)
        (!load && zero) |=> zero);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
    parameter int unsigned TOTAL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    output logic last
);
    localparam int unsigned W = $clog2(TOTAL + 1);

    logic [W-1:0] tally_q;

    always_ff @(posedge clk) begin
        if (rst)
            tally_q <= '0;
        else if (bump)
            tally_q <= tally_q + 1'b1;
    end

    assign last = (tally_q == W'(TOTAL));

    // R4: the sequencer never asks for more refreshes than configured
    a_r4_no_extra_refresh: assert property (@(posedge clk) disable iff (rst)
        bump |-> (tally_q < W'(TOTAL)));

    a_r4_tally_monotonic: assert property (@(posedge clk) disable iff (rst)
        !bump |=> (tally_q == $past(tally_q)));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned DQM_W         = 8,
    parameter int unsigned STABLE_CYC    = 40000,
    parameter int unsigned T_RP_CYC      = 4,
    parameter int unsigned T_RC_CYC      = 14,
    parameter int unsigned T_RSC_CYC     = 2,
    parameter int unsigned REFRESH_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_burst_len,
    input  logic              mode_interleave,
    input  logic [2:0]        mode_cas_lat,
    input  logic              mode_single_write,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int unsigned SETTLE_EFF = at_least(STABLE_CYC, 1);
    localparam int unsigned RP_EFF     = at_least(T_RP_CYC, 2);
    localparam int unsigned RC_EFF     = at_least(T_RC_CYC, 2);
    localparam int unsigned RSC_EFF    = at_least(T_RSC_CYC, 2);
    localparam int unsigned ARF_TOTAL  = at_least(REFRESH_COUNT, 8);
    localparam int unsigned SPAN_MAX   = max2(max2(SETTLE_EFF, RP_EFF), max2(RC_EFF, RSC_EFF));
    localparam int unsigned CNT_W      = $clog2(SPAN_MAX + 1);

    seq_state_e       state_q, state_d;
    logic             gap_zero;
    logic             gap_load;
    logic [CNT_W-1:0] gap_val;
    logic             arf_last;
    sd_cmd_e          cmd;
    mode_cfg_t        cfg;

    assign cfg = '{burst_len:    mode_burst_len,
                   interleave:   mode_interleave,
                   cas_lat:      mode_cas_lat,
                   single_write: mode_single_write};

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (SETTLE_EFF - 1)
    ) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    sdram_init_refcnt #(
        .TOTAL (ARF_TOTAL)
    ) u_arf (
        .clk  (clk),
        .rst  (rst),
        .bump (state_q == ST_ARF),
        .last (arf_last)
    );

    // Each command state arms the gap timer so the next command lands
    // exactly SPAN cycles after this one.
    always_comb begin
        gap_load = 1'b1;
        unique case (state_q)
            ST_PALL: gap_val = CNT_W'(RP_EFF - 2);
            ST_ARF:  gap_val = CNT_W'(RC_EFF - 2);
            ST_LMR:  gap_val = CNT_W'(RSC_EFF - 2);
            default: begin
                gap_val  = '0;
                gap_load = 1'b0;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE:  if (gap_zero) state_d = ST_PALL;
            ST_PALL:    state_d = ST_GAP_RP;
            ST_GAP_RP:  if (gap_zero) state_d = ST_ARF;
            ST_ARF:     state_d = ST_GAP_RC;
            ST_GAP_RC:  if (gap_zero) state_d = arf_last ? ST_LMR : ST_ARF;
            ST_LMR:     state_d = ST_GAP_RSC;
            ST_GAP_RSC: if (gap_zero) state_d = ST_READY;
            ST_READY:   state_d = ST_READY;
            default:    state_d = ST_SETTLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_SETTLE;
        else
            state_q <= state_d;
    end

    // Pin decode
    always_comb begin
        sd_addr = '0;
        unique case (state_q)
            ST_PALL: begin
                cmd = CMD_PALL;
                sd_addr[PALL_BIT] = 1'b1;
            end
            ST_ARF:  cmd = CMD_ARF;
            ST_LMR: begin
                cmd     = CMD_LMR;
                sd_addr = ADDR_W'(mode_word(cfg));
            end
            default: cmd = CMD_IDLE;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_ba     = '0;
    assign sd_cke    = 1'b1;
    assign sd_dqm    = '1;
    assign init_done = (state_q == ST_READY);

    // R7: every command occupies exactly one cycle and is followed by idle
    a_r7_cmd_then_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_IDLE) |=> (cmd == CMD_IDLE));

    // R5: the mode load only follows the full refresh train
    a_r5_lmr_after_refreshes: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LMR) |-> arf_last);

    // R6: ready is sticky and implies the whole train was issued
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r6_done_after_refreshes: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> arf_last);

    // R2: precharge-all is the first command after settling
    a_r2_pall_from_settle: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PALL) |-> ($past(state_q) == ST_SETTLE || $past(rst)));

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/100ps
module tb_sdram_init_seq;

    localparam int S_A = 50, RP_A = 4, RC_A = 14, N_A = 9, RSC_A = 3;
    localparam int S_B = 20, RP_B = 1, RC_B = 3,  N_B = 3, RSC_B = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] lfsr = 8'h5a;
    logic [2:0] m_bl, m_cl;
    logic m_bt, m_wm;

    always #2.5 clk = ~clk;

    assign m_bl = lfsr[2:0];
    assign m_bt = lfsr[3];
    assign m_cl = lfsr[6:4];
    assign m_wm = lfsr[7];

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [11:0] a_addr;
    logic [7:0]  a_dqm;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [11:0] b_addr;
    logic [7:0]  b_dqm;

    sdram_init_seq #(.STABLE_CYC(S_A), .T_RP_CYC(RP_A), .T_RC_CYC(RC_A),
                     .T_RSC_CYC(RSC_A), .REFRESH_COUNT(N_A)) dut (
        .clk(clk), .rst(rst), .mode_burst_len(m_bl), .mode_interleave(m_bt),
        .mode_cas_lat(m_cl), .mode_single_write(m_wm), .sd_cke(a_cke),
        .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
        .sd_ba(a_ba), .sd_addr(a_addr), .sd_dqm(a_dqm), .init_done(a_done));

    sdram_init_seq #(.STABLE_CYC(S_B), .T_RP_CYC(RP_B), .T_RC_CYC(RC_B),
                     .T_RSC_CYC(RSC_B), .REFRESH_COUNT(N_B)) dut_lo (
        .clk(clk), .rst(rst), .mode_burst_len(m_bl), .mode_interleave(m_bt),
        .mode_cas_lat(m_cl), .mode_single_write(m_wm), .sd_cke(b_cke),
        .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
        .sd_ba(b_ba), .sd_addr(b_addr), .sd_dqm(b_dqm), .init_done(b_done));

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int refs_a = 0, refs_b = 0;
    int pall_b = -1, ref1_b = -1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at k=%0d: actual=%h expected=%h", tag, what, k, act, exp);
        end
    endtask

    function automatic int flo2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    // Behavioural reference: expected pins at cycle k after release
    task automatic expect_at(input int kk, input int s, input int trp_raw,
                             input int trc_raw, input int n_raw, input int trsc_raw,
                             output logic [3:0] cmd, output logic [11:0] addr,
                             output logic done, output string tag);
        int trp = flo2(trp_raw);
        int trc = flo2(trc_raw);
        int trsc = flo2(trsc_raw);
        int n = (n_raw < 8) ? 8 : n_raw;
        int t_ref = s + trp;
        int t_mrs = t_ref + n * trc;
        cmd = 4'b0111; addr = 12'h000; done = 1'b0; tag = "R7";
        if (kk < s) tag = "R1";
        else if (kk == s) begin cmd = 4'b0010; addr = 12'h400; tag = "R2"; end
        else if (kk < t_ref) tag = "R7";
        else if (kk < t_mrs) begin
            if ((kk - t_ref) % trc == 0) begin
                cmd = 4'b0001;
                tag = (kk == t_ref) ? "R3" : "R4";
            end
        end else if (kk == t_mrs) begin
            cmd = 4'b0000;
            addr = {2'b00, m_wm, 2'b00, m_cl, m_bt, m_bl};
            tag = "R5";
        end else if (kk < t_mrs + trsc) tag = "R6";
        else begin done = 1'b1; tag = "R6"; end
    endtask

    task automatic compare_all();
        logic [3:0] ec; logic [11:0] ea; logic ed; string tg;
        logic [24:0] actv, expv;
        // design A
        if (rst) begin ec = 4'b0111; ea = '0; ed = 1'b0; tg = "R9"; end
        else expect_at(k, S_A, RP_A, RC_A, N_A, RSC_A, ec, ea, ed, tg);
        actv = {a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done};
        expv = {1'b1, 8'hff, ec, 2'b00, ea, ed};
        chk(actv == expv, tg, "dut pins", 32'(actv), 32'(expv));
        if (!rst && {a_cs, a_ras, a_cas, a_we} == 4'b0001) refs_a++;
        // design B
        if (rst) begin ec = 4'b0111; ea = '0; ed = 1'b0; tg = "R9"; end
        else expect_at(k, S_B, RP_B, RC_B, N_B, RSC_B, ec, ea, ed, tg);
        actv = {b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done};
        expv = {1'b1, 8'hff, ec, 2'b00, ea, ed};
        chk(actv == expv, (tg == "R3") ? "R8" : tg, "dut_lo pins", 32'(actv), 32'(expv));
        if (!rst && {b_cs, b_ras, b_cas, b_we} == 4'b0001) begin
            refs_b++;
            if (ref1_b < 0) ref1_b = k;
        end
        if (!rst && {b_cs, b_ras, b_cas, b_we} == 4'b0010) pall_b = k;
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            k++;
            @(posedge clk);
        end
    endtask

    // Mode inputs change every cycle, including the mode-load cycle (R7)
    initial begin
        forever begin
            @(posedge clk);
            #1 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: state during reset
        repeat (3) begin
            @(negedge clk);
            compare_all();
        end
        @(posedge clk);
        #1 rst = 1'b0;
        k = 0;
        run_cycles(220);
        chk(refs_a == 9, "R4", "dut refresh count", 32'(refs_a), 32'd9);
        chk(refs_b == 8, "R4", "dut_lo refresh floor", 32'(refs_b), 32'd8);
        chk(ref1_b - pall_b == 2, "R8", "dut_lo tRP floor", 32'(ref1_b - pall_b), 32'd2);
        chk(a_done && b_done, "R6", "ready held", {30'd0, a_done, b_done}, 32'd3);

        // R9: reset lands right after a refresh is on the pins
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        k = 0;
        run_cycles(S_A + RP_A + RC_A);
        @(negedge clk);
        compare_all();
        chk({a_cs, a_ras, a_cas, a_we} == 4'b0001, "R9", "refresh before reset",
            32'({a_cs, a_ras, a_cas, a_we}), 32'h1);
        rst = 1'b1;
        k++;
        @(posedge clk);
        @(negedge clk);
        chk({a_cs, a_ras, a_cas, a_we, a_done} == 5'b01110, "R9", "idle right after reset",
            32'({a_cs, a_ras, a_cas, a_we, a_done}), 32'he);
        compare_all();
        @(posedge clk);
        #1 rst = 1'b0;
        k = 0;
        refs_a = 0;
        refs_b = 0;
        run_cycles(220);
        chk(refs_a == 9, "R9", "dut refreshes after restart", 32'(refs_a), 32'd9);
        chk(a_done == 1'b1, "R9", "dut ready after restart", 32'(a_done), 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule